// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit computes the addresses a 16-bit, word-addressed processor needs while it executes one instruction. It takes the program counter (already advanced past the current instruction during fetch), the low bits of the instruction register and one general-register value. It produces three kinds of result: an address for the memory address register, a new program counter, or an address value to be written to a destination register. One shared adder forms either PC plus a sign-extended 9-bit offset or base register plus a sign-extended 6-bit offset. A separate path zero-extends an 8-bit service vector.

A control sequencer pulses `start` with a 3-bit operation code. Every result appears one cycle after the operation is accepted, as a single-cycle strobe. The indirect form needs one extra cycle. The unit first presents the pointer location on `mar_addr` with `busy` high, and memory returns the word there combinationally in that cycle. On the next cycle that word is issued as the final address. Addition wraps modulo 2^16. Writing data back and setting condition codes are done elsewhere.

Top module: `eau_top`

## Requirements
- R1: While reset is held and until the first accepted operation, `addr_valid`, `pc_load`, `lea_wr` and `busy` are 0 and `mar_addr` is 0x0000.
- R2: Code 0 (PC-relative): one cycle after acceptance, `addr_valid`=1 and `mar_addr` = `pc_inc` + sign-extended `ir_low[8:0]`, modulo 2^16.
- R3: Code 1 (base+offset): one cycle after acceptance, `addr_valid`=1 and `mar_addr` = `base_val` + sign-extended `ir_low[5:0]`, modulo 2^16. Bits 8:6 of `ir_low` have no effect.
- R4: Code 2 (indirect): one cycle after acceptance, `busy`=1, `addr_valid`=0 and `mar_addr` = `pc_inc` + sign-extended `ir_low[8:0]`. In the following cycle, `busy`=0, `addr_valid`=1 and `mar_addr` equals the `mem_rdata` seen during the busy cycle.
- R5: A `start` presented while `busy`=1 is ignored. It causes no strobe, and the final address of the indirect operation is unchanged.
- R6: Code 3 (load effective address): one cycle after acceptance, `lea_wr`=1 and `lea_val` = `pc_inc` + sign-extended `ir_low[8:0]`. At the same time `addr_valid`=0, `busy`=0, and `mar_addr` keeps its previous value.
- R7: Code 4 (service vector): one cycle after acceptance, `addr_valid`=1 and `mar_addr` = {8'h00, `ir_low[7:0]`}.
- R8: Code 5 (branch): `pc_load`=1 and `pc_next` = `pc_inc` + sign-extended `ir_low[8:0]`. Code 6 (register jump): `pc_load`=1 and `pc_next` = `base_val`. In both cases the result appears one cycle after acceptance.
- R9: Code 7, or a cycle without `start`, produces no strobe and leaves `mar_addr` unchanged.
- R10: `addr_valid`, `pc_load` and `lea_wr` are single-cycle strobes. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation this cycle |
| mode | input | 3 | Operation code (0..7, see R2-R9) |
| pc_inc | input | 16 | Program counter already advanced past the instruction |
| ir_low | input | 9 | Instruction register bits 8:0 |
| base_val | input | 16 | General-register value for base+offset or jump |
| mem_rdata | input | 16 | Word read from memory at `mar_addr` during busy |
| mar_addr | output | 16 | Memory-address-register input value |
| addr_valid | output | 1 | `mar_addr` holds a final access address |
| busy | output | 1 | Pointer fetch in progress; memory read at `mar_addr` |
| pc_next | output | 16 | Program-counter update value |
| pc_load | output | 1 | `pc_next` is to be loaded |
| lea_val | output | 16 | Computed address for the destination register |
| lea_wr | output | 1 | `lea_val` is to be written |

## Verification
The bench sweeps every 9-bit offset against program counters near zero, near 0x7FFF/0x8000 and near 0xFFFF. An adder that fails to sign-extend, or that keeps a carry beyond 16 bits, gives addresses off by 512 or outside the wrap there. It sweeps all 6-bit offsets with the unused high offset bits set to 1, and all 8-bit vectors with bit 8 set. A design that takes the wrong offset width, or sign-extends the vector, gives a wrong high byte or a wrong offset. For indirect operations the bench presents a competing `start` during the busy cycle. A sequencer that accepts it, or that issues the pointer location rather than the fetched word as the final address, reports the wrong `mar_addr` or an extra strobe. It also checks that the effective-address form and the reserved code leave `mar_addr` untouched and raise no memory strobe.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [2:0] {
    MODE_PCREL   = 3'd0,
    MODE_BASEOFF = 3'd1,
    MODE_INDIR   = 3'd2,
    MODE_LEA     = 3'd3,
    MODE_VECTOR  = 3'd4,
    MODE_BRANCH  = 3'd5,
    MODE_JREG    = 3'd6,
    MODE_RSVD    = 3'd7
  } eau_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PTR  = 1'b1
  } eau_state_e;

endpackage

// File: rtl/eau_ext.sv
module eau_ext #(
  parameter int unsigned IN_W     = 9,
  parameter int unsigned OUT_W    = 16,
  parameter bit          SIGN_EXT = 1'b1
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (SIGN_EXT) begin : g_sign
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_zero
      assign dout = {{PAD_W{1'b0}}, din};
    end
  endgenerate

endmodule

// File: rtl/eau_addr_gen.sv
module eau_addr_gen
  import eau_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned LONG_OFS_W  = 9,
  parameter int unsigned SHORT_OFS_W = 6,
  parameter int unsigned VEC_W       = 8
) (
  input  logic [2:0]            mode,
  input  logic [AW-1:0]         pc_inc,
  input  logic [AW-1:0]         base_val,
  input  logic [LONG_OFS_W-1:0] ir_low,
  output logic [AW-1:0]         adder_sum,
  output logic [AW-1:0]         vec_addr
);

  eau_mode_e     mode_e;
  logic [AW-1:0] ofs_long;
  logic [AW-1:0] ofs_short;
  logic [AW-1:0] opnd_a;
  logic [AW-1:0] opnd_b;
  logic          use_base;

  eau_ext #(.IN_W(LONG_OFS_W), .OUT_W(AW), .SIGN_EXT(1'b1)) u_ext_long (
    .din  (ir_low),
    .dout (ofs_long)
  );

  eau_ext #(.IN_W(SHORT_OFS_W), .OUT_W(AW), .SIGN_EXT(1'b1)) u_ext_short (
    .din  (ir_low[SHORT_OFS_W-1:0]),
    .dout (ofs_short)
  );

  eau_ext #(.IN_W(VEC_W), .OUT_W(AW), .SIGN_EXT(1'b0)) u_ext_vec (
    .din  (ir_low[VEC_W-1:0]),
    .dout (vec_addr)
  );

  always_comb begin
    mode_e   = eau_mode_e'(mode);
    use_base = (mode_e == MODE_BASEOFF);
    opnd_a   = use_base ? base_val  : pc_inc;
    opnd_b   = use_base ? ofs_short : ofs_long;
  end

  // Sum is truncated to AW bits: wraps modulo 2^AW.
  assign adder_sum = opnd_a + opnd_b;

endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned LONG_OFS_W  = 9,
  parameter int unsigned SHORT_OFS_W = 6,
  parameter int unsigned VEC_W       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            mode,
  input  logic [AW-1:0]         pc_inc,
  input  logic [LONG_OFS_W-1:0] ir_low,
  input  logic [AW-1:0]         base_val,
  input  logic [AW-1:0]         mem_rdata,
  output logic [AW-1:0]         mar_addr,
  output logic                  addr_valid,
  output logic                  busy,
  output logic [AW-1:0]         pc_next,
  output logic                  pc_load,
  output logic [AW-1:0]         lea_val,
  output logic                  lea_wr
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address datapath
  logic [AW-1:0] adder_sum;
  logic [AW-1:0] vec_addr;

  eau_addr_gen #(
    .AW(AW), .LONG_OFS_W(LONG_OFS_W), .SHORT_OFS_W(SHORT_OFS_W), .VEC_W(VEC_W)
  ) u_addr_gen (
    .mode      (mode),
    .pc_inc    (pc_inc),
    .base_val  (base_val),
    .ir_low    (ir_low),
    .adder_sum (adder_sum),
    .vec_addr  (vec_addr)
  );

  // State and result registers
  eau_state_e    state_q,    state_d;
  logic [AW-1:0] mar_q,      mar_d;
  logic [AW-1:0] pc_q,       pc_d;
  logic [AW-1:0] lea_q,      lea_d;
  logic          avld_q,     avld_d;
  logic          pcld_q,     pcld_d;
  logic          leawr_q,    leawr_d;
  logic          mar_en, pc_en, lea_en;
  eau_mode_e     mode_e;
  logic          accept;

  always_comb begin
    mode_e  = eau_mode_e'(mode);
    accept  = start && (state_q == ST_IDLE);
    state_d = state_q;
    mar_d   = mar_q;
    pc_d    = pc_q;
    lea_d   = lea_q;
    avld_d  = 1'b0;
    pcld_d  = 1'b0;
    leawr_d = 1'b0;
    if (state_q == ST_PTR) begin
      mar_d   = mem_rdata;
      avld_d  = 1'b1;
      state_d = ST_IDLE;
    end else if (accept) begin
      unique case (mode_e)
        MODE_PCREL, MODE_BASEOFF: begin
          mar_d  = adder_sum;
          avld_d = 1'b1;
        end
        MODE_INDIR: begin
          mar_d   = adder_sum;
          state_d = ST_PTR;
        end
        MODE_LEA: begin
          lea_d   = adder_sum;
          leawr_d = 1'b1;
        end
        MODE_VECTOR: begin
          mar_d  = vec_addr;
          avld_d = 1'b1;
        end
        MODE_BRANCH: begin
          pc_d   = adder_sum;
          pcld_d = 1'b1;
        end
        MODE_JREG: begin
          pc_d   = base_val;
          pcld_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mar_en = (mar_d != mar_q);
  assign pc_en  = pcld_d;
  assign lea_en = leawr_d;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      avld_q  <= 1'b0;
      pcld_q  <= 1'b0;
      leawr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      avld_q  <= avld_d;
      pcld_q  <= pcld_d;
      leawr_q <= leawr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mar_q <= '0;
      pc_q  <= '0;
      lea_q <= '0;
    end else begin
      if (mar_en) mar_q <= mar_d;
      if (pc_en)  pc_q  <= pc_d;
      if (lea_en) lea_q <= lea_d;
    end
  end

  assign mar_addr   = mar_q;
  assign addr_valid = avld_q;
  assign busy       = (state_q == ST_PTR);
  assign pc_next    = pc_q;
  assign pc_load    = pcld_q;
  assign lea_val    = lea_q;
  assign lea_wr     = leawr_q;

endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] mem_rdata,
  input logic [AW-1:0] mar_addr,
  input logic          addr_valid,
  input logic          busy,
  input logic [AW-1:0] pc_next,
  input logic          pc_load,
  input logic          lea_wr
);

  AST_PTR_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> !busy); // R4

  AST_FINAL_FROM_POINTER: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> (addr_valid && mar_addr == $past(mem_rdata))); // R4

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start) |=> (!pc_load && !lea_wr)); // R5

  AST_LEA_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && mode == 3'd3) |=> (lea_wr && !addr_valid && !busy && $stable(mar_addr))); // R6

  AST_VECTOR_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && mode == 3'd4) |=> (addr_valid && mar_addr[AW-1:8] == '0)); // R7

  AST_JUMP_FULL_TARGET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && mode == 3'd6) |=> (pc_load && pc_next == $past(base_val))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((!start || mode == 3'd7) && !busy) |=> (!addr_valid && !pc_load && !lea_wr && $stable(mar_addr))); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({addr_valid, pc_load, lea_wr})); // R10

endmodule

bind eau_top eau_chk #(.AW(AW)) u_eau_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .start      (start),
  .mode       (mode),
  .base_val   (base_val),
  .mem_rdata  (mem_rdata),
  .mar_addr   (mar_addr),
  .addr_valid (addr_valid),
  .busy       (busy),
  .pc_next    (pc_next),
  .pc_load    (pc_load),
  .lea_wr     (lea_wr)
);

// File: tb/eau_top_tb_top.sv
`timescale 1ns/1ps
module eau_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [15:0] pc_inc;
  logic [8:0]  ir_low;
  logic [15:0] base_val;
  logic [15:0] mem_rdata;
  logic [15:0] mar_addr;
  logic        addr_valid;
  logic        busy;
  logic [15:0] pc_next;
  logic        pc_load;
  logic [15:0] lea_val;
  logic        lea_wr;

  always #2 clk = ~clk;

  eau_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_inc(pc_inc),
    .ir_low(ir_low), .base_val(base_val), .mem_rdata(mem_rdata),
    .mar_addr(mar_addr), .addr_valid(addr_valid), .busy(busy),
    .pc_next(pc_next), .pc_load(pc_load), .lea_val(lea_val), .lea_wr(lea_wr)
  );

  // Single-cycle memory model, combinational read
  logic [15:0] mem [256];

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'hC3, a} ^ 16'h0F0F;
  endfunction

  assign mem_rdata = mem[mar_addr[7:0]];

  int n_run  = 0;
  int n_fail = 0;

  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction

  function automatic logic [15:0] sx6(input logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one operation; returns at the falling edge after capture.
  task automatic issue(input logic [2:0] m, input logic [15:0] pc,
                       input logic [8:0] irl, input logic [15:0] base);
    @(negedge clk);
    start = 1'b1; mode = m; pc_inc = pc; ir_low = irl; base_val = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  logic [15:0] pcs [6] = '{16'h0000, 16'h3000, 16'h7FFF, 16'h8000, 16'hFF00, 16'hFFFF};
  logic [15:0] bases [5] = '{16'h0000, 16'h0005, 16'hFFFE, 16'h8000, 16'h1234};

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] prev_mar;
    logic [15:0] ploc;
    for (int i = 0; i < 256; i++) mem[i] = mem_word(8'(i));
    rst_n = 1'b0; start = 1'b0; mode = 3'd0; pc_inc = '0; ir_low = '0; base_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {15'd0, addr_valid}, 16'd0);
    chk("R1 pcld",  {15'd0, pc_load}, 16'd0);
    chk("R1 leawr", {15'd0, lea_wr}, 16'd0);
    chk("R1 busy",  {15'd0, busy}, 16'd0);
    chk("R1 mar",   mar_addr, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mar after release", mar_addr, 16'h0000);
    chk("R1 busy after release", {15'd0, busy}, 16'd0);

    // R2: PC-relative sweep over every 9-bit offset
    foreach (pcs[p]) begin
      for (int o = 0; o < 512; o++) begin
        issue(3'd0, pcs[p], 9'(o), 16'hA5A5);
        chk("R2 valid", {15'd0, addr_valid}, 16'd1);
        chk("R2 mar", mar_addr, pcs[p] + sx9(9'(o)));
      end
    end

    // R10: strobe drops the cycle after
    @(negedge clk);
    chk("R10 valid drops", {15'd0, addr_valid}, 16'd0);
    chk("R10 pcld low", {15'd0, pc_load}, 16'd0);

    // R3: base+offset, upper offset bits set and ignored
    foreach (bases[b]) begin
      for (int o = 0; o < 64; o++) begin
        issue(3'd1, 16'h4444, {3'b111, 6'(o)}, bases[b]);
        chk("R3 valid", {15'd0, addr_valid}, 16'd1);
        chk("R3 mar", mar_addr, bases[b] + sx6(6'(o)));
      end
    end

    // R7: service vectors with bit 8 set
    for (int v = 0; v < 256; v++) begin
      issue(3'd4, 16'hFFFF, {1'b1, 8'(v)}, 16'hFFFF);
      chk("R7 valid", {15'd0, addr_valid}, 16'd1);
      chk("R7 mar", mar_addr, {8'h00, 8'(v)});
    end

    // R6: load effective address
    for (int p = 4; p < 6; p++) begin
      for (int o = 0; o < 512; o += 3) begin
        prev_mar = mar_addr;
        issue(3'd3, pcs[p], 9'(o), 16'h0);
        chk("R6 leawr", {15'd0, lea_wr}, 16'd1);
        chk("R6 leaval", lea_val, pcs[p] + sx9(9'(o)));
        chk("R6 no access", {14'd0, addr_valid, busy}, 16'd0);
        chk("R6 mar held", mar_addr, prev_mar);
      end
    end

    // R8: branch and register jump
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 512; o += 5) begin
        issue(3'd5, pcs[p], 9'(o), 16'h1111);
        chk("R8 branch load", {15'd0, pc_load}, 16'd1);
        chk("R8 branch target", pc_next, pcs[p] + sx9(9'(o)));
      end
    end
    foreach (bases[b]) begin
      issue(3'd6, 16'h2222, 9'h1FF, bases[b]);
      chk("R8 jump load", {15'd0, pc_load}, 16'd1);
      chk("R8 jump target", pc_next, bases[b]);
      chk("R10 jump no mem strobe", {15'd0, addr_valid}, 16'd0);
    end

    // R4/R5: indirect with competing start during the busy cycle
    foreach (pcs[p]) begin
      for (int o = 0; o < 512; o += 37) begin
        ploc = pcs[p] + sx9(9'(o));
        issue(3'd2, pcs[p], 9'(o), 16'h0);
        chk("R4 busy", {15'd0, busy}, 16'd1);
        chk("R4 no early valid", {15'd0, addr_valid}, 16'd0);
        chk("R4 pointer loc", mar_addr, ploc);
        start = 1'b1; mode = 3'd5; pc_inc = 16'h0BAD; ir_low = 9'h0F0;
        @(negedge clk);
        start = 1'b0;
        chk("R4 busy drops", {15'd0, busy}, 16'd0);
        chk("R4 final valid", {15'd0, addr_valid}, 16'd1);
        chk("R4 final addr", mar_addr, mem_word(ploc[7:0]));
        chk("R5 no branch", {15'd0, pc_load}, 16'd0);
        @(negedge clk);
        chk("R5 no late strobe", {13'd0, addr_valid, pc_load, lea_wr}, 16'd0);
        chk("R5 mar kept", mar_addr, mem_word(ploc[7:0]));
      end
    end

    // R9: reserved code and idle cycles
    for (int k = 0; k < 8; k++) begin
      prev_mar = mar_addr;
      issue(3'd7, 16'(k * 16'h1357), 9'(k * 61), 16'hBEEF);
      chk("R9 reserved strobes", {12'd0, addr_valid, pc_load, lea_wr, busy}, 16'd0);
      chk("R9 reserved mar", mar_addr, prev_mar);
      @(negedge clk);
      chk("R9 idle strobes", {12'd0, addr_valid, pc_load, lea_wr, busy}, 16'd0);
      chk("R9 idle mar", mar_addr, prev_mar);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule